// File: doc/BRIEF.md
# DTMF Dial Tone Sequencer

This block produces one dual-tone dialing cycle each time software writes a 4-bit key code. The code picks one of four low-group (row) frequencies and one of four high-group (column) frequencies. Two phase accumulators, advanced by a sample-rate enable, index one shared sine lookup. The output is the sum of the two group samples, or one group alone when the output-select field asks for it. When no tone is playing the output sits at zero.

A sequencer measures the tone-on period and the silent inter-digit gap from a 1 kHz millisecond enable. A continuous-tone input can stretch the tone beyond its guaranteed minimum. An active-low transmit-mute output is held low for the whole cycle and for a short hold window after it. A new digit written inside that window keeps the mute low without a break. When a cycle finishes, an interrupt flag is set. Reading the flag clears it, and a software enable bit masks the request line.

Top module: `dtmf_seq`

## Requirements
- R1: After reset, tone_out is 0, tx_mute_n is 1, int_flag and int_req are 0, the stored key code is 0, the output select is dual, the interrupt enable is 0 and the tone/pulse bit is 0 (tone mode).
- R2: A write to address 0 starts a cycle only when offhook is 1, the tone/pulse bit (address 2, bit 1) is 0, and no tone or gap is in progress. Any other code write is ignored: no tone starts and the running cycle keeps its timing.
- R3: Key codes map to (row, column) indices 0..3 as follows: 0→(0,3), 1→(0,0), 2→(0,1), 3→(0,2), 4→(1,0), 5→(1,1), 6→(1,2), 7→(2,0), 8→(2,1), 9→(2,2), 10→(3,1), 11→(3,2), 12→(3,0), 13→(1,3), 14→(3,3), 15→(2,3).
- R4: At cycle start both 16-bit phases are 0. Each sample tick during the tone adds round(f·65536/SAMPLE_HZ) to a phase, with row frequencies 697, 770, 852, 941 Hz and column frequencies 1209, 1336, 1477, 1633 Hz. A group sample is 64 ± round(63·|sin((p+0.5)·π/32)|), where p is the phase's top 6 bits and the sign is that of the sine.
- R5: Output select (address 1, bits 1:0): 01 gives the row sample alone, 10 gives the column sample alone, 00 and 11 give the sum of the two. tone_out follows the select one clock after it changes.
- R6: With cont_tone at 0, the tone ends on the TONE_MS-th millisecond tick after the start (94 by default).
- R7: While cont_tone is 1, the tone continues past the minimum. The tone ends on the first tick at which cont_tone is 0 and at least TONE_MS ticks have been counted, so a release before the minimum still gives TONE_MS ticks.
- R8: The gap after the tone lasts GAP_MS ticks (94 by default). tone_out is 0 throughout the gap.
- R9: tx_mute_n is 0 from the cycle start through the gap and for HOLD_MS ticks after it (4 by default), then returns to 1. A code accepted within that hold keeps tx_mute_n at 0 continuously.
- R10: int_flag is set on the tick that ends the gap and is cleared by a one-clock int_rd pulse.
- R11: int_req equals int_flag gated by the interrupt enable (address 2, bit 0).
- R12: tone_out is 0 whenever no tone is playing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 key code, 1 output select, 2 config |
| wr_data | input | 4 | Write data |
| int_rd | input | 1 | Interrupt flag read strobe; clears the flag |
| offhook | input | 1 | Off-hook enable; dialing only while 1 |
| cont_tone | input | 1 | Continuous-tone request |
| ms_tick | input | 1 | 1 kHz timing enable, one clock wide |
| smp_tick | input | 1 | Sample-rate enable, one clock wide |
| tone_out | output | 8 | Registered tone sample, 0 when silent |
| tx_mute_n | output | 1 | Active-low transmit mute |
| int_flag | output | 1 | Cycle-complete flag |
| int_req | output | 1 | Masked interrupt request |

## Verification
The assertions check the following on every cycle:
- a nonzero tone sample only ever appears while the mute is low;
- the output is zero outside the tone;
- a tone begins only after an off-hook write;
- the tone never ends before the minimum tick count;
- the mute is released only after exactly the hold count;
- the flag rises only on gap completion and falls after a read;
- the request never shows without the flag.

The bench scenarios alone can show the rest:
- the frequency content of each of the 16 key codes in every select mode;
- the stretch behaviour of the continuous-tone bit;
- a digit arriving inside the hold window;
- writes that must be ignored because the hook is on, pulse mode is chosen, or a cycle is in progress.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

   localparam int SMP_W   = 7;
   localparam int SMP_MID = 64;
   localparam int GRP_N   = 4;
   localparam int LUT_W   = 6;

   localparam logic [1:0] RA_CODE = 2'd0;
   localparam logic [1:0] RA_SEL  = 2'd1;
   localparam logic [1:0] RA_CFG  = 2'd2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_TONE = 2'd1,
      ST_GAP  = 2'd2
   } seq_st_t;

   typedef enum logic [1:0] {
      OUT_DUAL = 2'b00,
      OUT_ROW  = 2'b01,
      OUT_COL  = 2'b10,
      OUT_BOTH = 2'b11
   } out_sel_t;

   typedef struct packed {
      logic [1:0] row;
      logic [1:0] col;
   } grid_pos_t;

   function automatic int group_hz(input bit is_col, input int idx);
      int hz;
      if (is_col) begin
         case (idx)
            0:       hz = 1209;
            1:       hz = 1336;
            2:       hz = 1477;
            default: hz = 1633;
         endcase
      end else begin
         case (idx)
            0:       hz = 697;
            1:       hz = 770;
            2:       hz = 852;
            default: hz = 941;
         endcase
      end
      return hz;
   endfunction

   function automatic longint unsigned phase_step(input int hz, input int fs, input int accw);
      longint unsigned num;
      num = (longint'(hz) << accw) + longint'(fs / 2);
      return num / longint'(fs);
   endfunction

   function automatic logic [SMP_W-1:0] sine_lut(input logic [LUT_W-1:0] ph);
      logic [3:0] qi;
      logic [5:0] mag;
      qi = ph[4] ? ~ph[3:0] : ph[3:0];
      case (qi)
         4'd0:  mag = 6'd3;
         4'd1:  mag = 6'd9;
         4'd2:  mag = 6'd15;
         4'd3:  mag = 6'd21;
         4'd4:  mag = 6'd27;
         4'd5:  mag = 6'd32;
         4'd6:  mag = 6'd38;
         4'd7:  mag = 6'd42;
         4'd8:  mag = 6'd47;
         4'd9:  mag = 6'd51;
         4'd10: mag = 6'd54;
         4'd11: mag = 6'd57;
         4'd12: mag = 6'd59;
         4'd13: mag = 6'd61;
         4'd14: mag = 6'd62;
         default: mag = 6'd63;
      endcase
      return ph[5] ? SMP_W'(SMP_MID - int'(mag)) : SMP_W'(SMP_MID + int'(mag));
   endfunction

endpackage

// File: rtl/dtmf_keymap.sv
module dtmf_keymap
   import dtmf_pkg::*;
(
   input  logic [3:0] code,
   output grid_pos_t  pos
);

   always_comb begin
      case (code)
         4'd0:  pos = '{row: 2'd0, col: 2'd3};
         4'd1:  pos = '{row: 2'd0, col: 2'd0};
         4'd2:  pos = '{row: 2'd0, col: 2'd1};
         4'd3:  pos = '{row: 2'd0, col: 2'd2};
         4'd4:  pos = '{row: 2'd1, col: 2'd0};
         4'd5:  pos = '{row: 2'd1, col: 2'd1};
         4'd6:  pos = '{row: 2'd1, col: 2'd2};
         4'd7:  pos = '{row: 2'd2, col: 2'd0};
         4'd8:  pos = '{row: 2'd2, col: 2'd1};
         4'd9:  pos = '{row: 2'd2, col: 2'd2};
         4'd10: pos = '{row: 2'd3, col: 2'd1};
         4'd11: pos = '{row: 2'd3, col: 2'd2};
         4'd12: pos = '{row: 2'd3, col: 2'd0};
         4'd13: pos = '{row: 2'd1, col: 2'd3};
         4'd14: pos = '{row: 2'd3, col: 2'd3};
         default: pos = '{row: 2'd2, col: 2'd3};
      endcase
   end

endmodule

// File: rtl/dtmf_osc.sv
module dtmf_osc
   import dtmf_pkg::*;
#(
   parameter int ACC_W     = 16,
   parameter int SAMPLE_HZ = 8000,
   parameter bit IS_COL    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [1:0]       idx,
   output logic [SMP_W-1:0] smp
);

   logic [ACC_W-1:0] step_tab [GRP_N];
   logic [ACC_W-1:0] acc_q;

   if (IS_COL) begin : g_col
      for (genvar i = 0; i < GRP_N; i++) begin : g_step
         localparam longint unsigned STEP = phase_step(group_hz(1'b1, i), SAMPLE_HZ, ACC_W);
         assign step_tab[i] = STEP[ACC_W-1:0];
      end
   end else begin : g_row
      for (genvar i = 0; i < GRP_N; i++) begin : g_step
         localparam longint unsigned STEP = phase_step(group_hz(1'b0, i), SAMPLE_HZ, ACC_W);
         assign step_tab[i] = STEP[ACC_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clr) begin
         acc_q <= '0;
      end else if (adv) begin
         acc_q <= acc_q + step_tab[idx];
      end
   end

   assign smp = sine_lut(acc_q[ACC_W-1 -: LUT_W]);

endmodule

// File: rtl/dtmf_timer.sv
module dtmf_timer
   import dtmf_pkg::*;
#(
   parameter int TONE_MS = 94,
   parameter int GAP_MS  = 94,
   parameter int HOLD_MS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic allow,
   input  logic ms_tick,
   input  logic stretch,
   output logic start_ok,
   output logic tone_on,
   output logic busy,
   output logic hold_act,
   output logic done
);

   localparam int PER_MAX = (TONE_MS > GAP_MS) ? TONE_MS : GAP_MS;
   localparam int CNT_W   = $clog2(PER_MAX + 1);
   localparam int HLD_W   = $clog2(HOLD_MS + 1);
   localparam logic [CNT_W-1:0] TONE_LAST = CNT_W'(TONE_MS - 1);
   localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_MS - 1);
   localparam logic [HLD_W-1:0] HOLD_LAST = HLD_W'(HOLD_MS - 1);

   seq_st_t          st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [HLD_W-1:0] hcnt_q;
   logic             hold_q;

   assign start_ok = start_req && allow && (st_q == ST_IDLE);
   assign done     = ms_tick && (st_q == ST_GAP) && (cnt_q == GAP_LAST);
   assign tone_on  = (st_q == ST_TONE);
   assign busy     = (st_q != ST_IDLE);
   assign hold_act = hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         hcnt_q <= '0;
         hold_q <= 1'b0;
      end else if (start_ok) begin
         st_q   <= ST_TONE;
         cnt_q  <= '0;
         hcnt_q <= '0;
         hold_q <= 1'b0;
      end else begin
         case (st_q)
            ST_TONE: begin
               if (ms_tick) begin
                  if (cnt_q == TONE_LAST) begin
                     if (!stretch) begin
                        st_q  <= ST_GAP;
                        cnt_q <= '0;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_GAP: begin
               if (ms_tick) begin
                  if (cnt_q == GAP_LAST) begin
                     st_q   <= ST_IDLE;
                     cnt_q  <= '0;
                     hold_q <= 1'b1;
                     hcnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: begin
               if (hold_q && ms_tick) begin
                  if (hcnt_q == HOLD_LAST) begin
                     hold_q <= 1'b0;
                  end else begin
                     hcnt_q <= hcnt_q + 1'b1;
                  end
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/dtmf_seq.sv
module dtmf_seq
   import dtmf_pkg::*;
#(
   parameter int ACC_W     = 16,
   parameter int SAMPLE_HZ = 8000,
   parameter int TONE_MS   = 94,
   parameter int GAP_MS    = 94,
   parameter int HOLD_MS   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [1:0]           wr_addr,
   input  logic [3:0]           wr_data,
   input  logic                 int_rd,
   input  logic                 offhook,
   input  logic                 cont_tone,
   input  logic                 ms_tick,
   input  logic                 smp_tick,
   output logic [SMP_W:0]       tone_out,
   output logic                 tx_mute_n,
   output logic                 int_flag,
   output logic                 int_req
);

   localparam int OUT_W = SMP_W + 1;

   if (ACC_W < LUT_W + 2 || ACC_W > 32) begin : g_bad_acc
      $error("dtmf_seq: ACC_W out of range");
   end
   if (SAMPLE_HZ < 2 * 1633) begin : g_bad_fs
      $error("dtmf_seq: SAMPLE_HZ below twice the top column frequency");
   end
   if (TONE_MS < 1 || GAP_MS < 1 || HOLD_MS < 1) begin : g_bad_time
      $error("dtmf_seq: timing parameters must be at least 1");
   end

   logic [3:0]       code_q;
   out_sel_t         sel_q;
   logic             ie_q;
   logic             pulse_q;
   logic             flag_q;
   logic [OUT_W-1:0] tone_q;
   logic [OUT_W-1:0] mix;
   logic             start_req;
   logic             start_ok;
   logic             tone_on;
   logic             busy;
   logic             hold_act;
   logic             done;
   grid_pos_t        pos;
   logic [SMP_W-1:0] smp [2];

   assign start_req = wr_en && (wr_addr == RA_CODE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q  <= '0;
         sel_q   <= OUT_DUAL;
         ie_q    <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         if (start_ok) begin
            code_q <= wr_data;
         end
         if (wr_en && wr_addr == RA_SEL) begin
            sel_q <= out_sel_t'(wr_data[1:0]);
         end
         if (wr_en && wr_addr == RA_CFG) begin
            ie_q    <= wr_data[0];
            pulse_q <= wr_data[1];
         end
      end
   end

   dtmf_timer #(
      .TONE_MS (TONE_MS),
      .GAP_MS  (GAP_MS),
      .HOLD_MS (HOLD_MS)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (start_req),
      .allow     (offhook && !pulse_q),
      .ms_tick   (ms_tick),
      .stretch   (cont_tone),
      .start_ok  (start_ok),
      .tone_on   (tone_on),
      .busy      (busy),
      .hold_act  (hold_act),
      .done      (done)
   );

   dtmf_keymap u_keymap (
      .code (code_q),
      .pos  (pos)
   );

   for (genvar g = 0; g < 2; g++) begin : g_grp
      dtmf_osc #(
         .ACC_W     (ACC_W),
         .SAMPLE_HZ (SAMPLE_HZ),
         .IS_COL    (g == 1)
      ) u_osc (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (start_ok),
         .adv   (smp_tick && tone_on),
         .idx   ((g == 1) ? pos.col : pos.row),
         .smp   (smp[g])
      );
   end

   always_comb begin
      case (sel_q)
         OUT_ROW: mix = {1'b0, smp[0]};
         OUT_COL: mix = {1'b0, smp[1]};
         default: mix = {1'b0, smp[0]} + {1'b0, smp[1]};
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tone_q <= '0;
         flag_q <= 1'b0;
      end else begin
         tone_q <= tone_on ? mix : '0;
         if (done) begin
            flag_q <= 1'b1;
         end else if (int_rd) begin
            flag_q <= 1'b0;
         end
      end
   end

   assign tone_out  = tone_q;
   assign tx_mute_n = !(busy || hold_act);
   assign int_flag  = flag_q;
   assign int_req   = flag_q && ie_q;

endmodule

// File: rtl/dtmf_seq_chk.sv
module dtmf_seq_chk #(
   parameter int TONE_MS = 94,
   parameter int HOLD_MS = 4,
   parameter int OUT_W   = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ms_tick,
   input logic             offhook,
   input logic             int_rd,
   input logic             tone_on,
   input logic             hold_act,
   input logic             done,
   input logic             tx_mute_n,
   input logic             int_flag,
   input logic             int_req,
   input logic [OUT_W-1:0] tone_out
);

   localparam int TW = $clog2(TONE_MS + 1);
   localparam int HW = $clog2(HOLD_MS + 1);

   logic [TW-1:0] t_cnt;
   logic [HW-1:0] h_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !tone_on) begin
         t_cnt <= '0;
      end else if (ms_tick && t_cnt != TW'(TONE_MS)) begin
         t_cnt <= t_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !hold_act) begin
         h_cnt <= '0;
      end else if (ms_tick && h_cnt != HW'(HOLD_MS)) begin
         h_cnt <= h_cnt + 1'b1;
      end
   end

   p_tone_muted_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tone_out != '0) |-> !tx_mute_n);

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!tone_on && !$past(tone_on)) |-> (tone_out == '0));

   p_start_offhook_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tone_on) |-> $past(offhook));

   p_min_tone_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tone_on) |-> (t_cnt == TW'(TONE_MS)));

   p_hold_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_mute_n) |-> (h_cnt == HW'(HOLD_MS)));

   p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_flag) |-> $past(done));

   p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (int_rd && !done) |=> !int_flag);

   p_req_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> int_flag);

endmodule

bind dtmf_seq dtmf_seq_chk #(
   .TONE_MS (TONE_MS),
   .HOLD_MS (HOLD_MS),
   .OUT_W   (OUT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ms_tick   (ms_tick),
   .offhook   (offhook),
   .int_rd    (int_rd),
   .tone_on   (tone_on),
   .hold_act  (hold_act),
   .done      (done),
   .tx_mute_n (tx_mute_n),
   .int_flag  (int_flag),
   .int_req   (int_req),
   .tone_out  (tone_out)
);

// File: tb/sim_dtmf_seq.sv
module sim_dtmf_seq;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 150000;
   localparam int T_TONE     = 94;
   localparam int T_GAP      = 94;
   localparam int T_HOLD     = 4;
   localparam int FS         = 8000;

   // {code, row index, column index}
   localparam logic [7:0] VEC [16] = '{
      {4'd0,  2'd0, 2'd3}, {4'd1,  2'd0, 2'd0}, {4'd2,  2'd0, 2'd1}, {4'd3,  2'd0, 2'd2},
      {4'd4,  2'd1, 2'd0}, {4'd5,  2'd1, 2'd1}, {4'd6,  2'd1, 2'd2}, {4'd7,  2'd2, 2'd0},
      {4'd8,  2'd2, 2'd1}, {4'd9,  2'd2, 2'd2}, {4'd10, 2'd3, 2'd1}, {4'd11, 2'd3, 2'd2},
      {4'd12, 2'd3, 2'd0}, {4'd13, 2'd1, 2'd3}, {4'd14, 2'd3, 2'd3}, {4'd15, 2'd2, 2'd3}
   };
   localparam int ROW_F [4] = '{697, 770, 852, 941};
   localparam int COL_F [4] = '{1209, 1336, 1477, 1633};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [3:0] wr_data = '0;
   logic       int_rd = 1'b0;
   logic       offhook = 1'b1;
   logic       cont_tone = 1'b0;
   logic       ms_tick = 1'b0;
   logic       smp_tick = 1'b0;
   logic [7:0] tone_out;
   logic       tx_mute_n;
   logic       int_flag;
   logic       int_req;

   int n_chk = 0;
   int n_err = 0;

   dtmf_seq u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .int_rd    (int_rd),
      .offhook   (offhook),
      .cont_tone (cont_tone),
      .ms_tick   (ms_tick),
      .smp_tick  (smp_tick),
      .tone_out  (tone_out),
      .tx_mute_n (tx_mute_n),
      .int_flag  (int_flag),
      .int_req   (int_req)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic int exp_smp(input int hz, input int k);
      longint inc;
      longint ph;
      int     p;
      real    v;
      int     m;
      inc = (longint'(hz) * 65536 + FS / 2) / FS;
      ph  = (longint'(k) * inc) % 65536;
      p   = int'(ph >> 10);
      v   = 63.0 * $sin((real'(p) + 0.5) * 3.14159265358979 / 32.0);
      m   = $rtoi(((v < 0.0) ? -v : v) + 0.5);
      return (v < 0.0) ? 64 - m : 64 + m;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [3:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ms(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) ms_tick = 1'b1;
         @(negedge clk) ms_tick = 1'b0;
      end
   endtask

   task automatic smp(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) smp_tick = 1'b1;
         @(negedge clk) smp_tick = 1'b0;
      end
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   task automatic rd();
      @(negedge clk) int_rd = 1'b1;
      @(negedge clk) int_rd = 1'b0;
   endtask

   task automatic drain();
      ms(T_TONE);
      ms(T_GAP);
      ms(T_HOLD);
      rd();
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_err++;
      $display("FAIL R6 watchdog actual %0d expected below %0d cycles", WD_CYCLES, WD_CYCLES);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 tone_out", tone_out, 0);
      chk("R1 tx_mute_n", tx_mute_n, 1);
      chk("R1 int_flag", int_flag, 0);
      chk("R1 int_req", int_req, 0);

      // R6 R8 R9 R10 R11 nominal timing, default dual select (R5)
      wr(2'd2, 4'd1);
      wr(2'd0, 4'd5);
      chk("R9 mute at start", tx_mute_n, 0);
      settle();
      chk("R5 default dual sum", tone_out, 2 * exp_smp(ROW_F[1], 0));
      ms(T_TONE - 1);
      settle();
      chk("R6 tone before minimum", int'(tone_out != 0), 1);
      ms(1);
      settle();
      chk("R6 tone ends at minimum", tone_out, 0);
      chk("R9 mute in gap", tx_mute_n, 0);
      wr(2'd0, 4'd3);
      settle();
      chk("R2 write in gap ignored", tone_out, 0);
      ms(T_GAP - 1);
      chk("R10 flag before gap end", int_flag, 0);
      chk("R12 gap silent", tone_out, 0);
      ms(1);
      chk("R10 flag at gap end", int_flag, 1);
      chk("R11 req enabled", int_req, 1);
      chk("R8 mute after gap", tx_mute_n, 0);
      ms(T_HOLD - 1);
      chk("R9 mute in hold", tx_mute_n, 0);
      ms(1);
      chk("R9 mute released", tx_mute_n, 1);
      rd();
      chk("R10 flag cleared", int_flag, 0);
      chk("R11 req cleared", int_req, 0);

      // R11 masked request
      wr(2'd2, 4'd0);
      wr(2'd0, 4'd7);
      ms(T_TONE);
      ms(T_GAP);
      chk("R11 masked flag", int_flag, 1);
      chk("R11 masked req", int_req, 0);
      // R9 back-to-back digit within hold
      ms(T_HOLD - 2);
      chk("R9 hold before redial", tx_mute_n, 0);
      wr(2'd0, 4'd1);
      chk("R9 mute kept on redial", tx_mute_n, 0);
      settle();
      chk("R9 redial tone", tone_out, 2 * exp_smp(ROW_F[0], 0));
      rd();
      drain();

      // R7 stretch beyond minimum
      cont_tone = 1'b1;
      wr(2'd0, 4'd8);
      ms(T_TONE + 56);
      settle();
      chk("R7 tone held by cont_tone", int'(tone_out != 0), 1);
      cont_tone = 1'b0;
      ms(1);
      settle();
      chk("R7 tone ends after release", tone_out, 0);
      ms(T_GAP);
      ms(T_HOLD);
      rd();

      // R7 early release extended to minimum
      cont_tone = 1'b1;
      wr(2'd0, 4'd2);
      ms(50);
      cont_tone = 1'b0;
      ms(T_TONE - 51);
      settle();
      chk("R7 early release still on", int'(tone_out != 0), 1);
      ms(1);
      settle();
      chk("R7 early release ends at minimum", tone_out, 0);
      ms(T_GAP);
      ms(T_HOLD);
      rd();

      // R2 on-hook and pulse mode block dialing
      offhook = 1'b0;
      wr(2'd0, 4'd2);
      settle();
      chk("R2 on-hook no tone", tone_out, 0);
      chk("R2 on-hook no mute", tx_mute_n, 1);
      offhook = 1'b1;
      wr(2'd2, 4'd2);
      wr(2'd0, 4'd2);
      settle();
      chk("R2 pulse mode no tone", tone_out, 0);
      chk("R2 pulse mode no mute", tx_mute_n, 1);
      wr(2'd2, 4'd0);

      // R5 select 11 sums both groups
      wr(2'd1, 4'd3);
      wr(2'd0, 4'd9);
      settle();
      chk("R5 select 11 dual", tone_out, exp_smp(ROW_F[2], 0) + exp_smp(COL_F[2], 0));
      drain();

      // R3 R4 R5 sweep of every key code
      for (int i = 0; i < 16; i++) begin
         int k;
         int er;
         int ec;
         k  = i + 3;
         er = exp_smp(ROW_F[VEC[i][3:2]], k);
         ec = exp_smp(COL_F[VEC[i][1:0]], k);
         wr(2'd1, 4'd0);
         wr(2'd0, VEC[i][7:4]);
         smp(k);
         settle();
         chk($sformatf("R3 R4 code %0d dual", i), tone_out, er + ec);
         wr(2'd1, 4'd1);
         settle();
         chk($sformatf("R5 code %0d row only", i), tone_out, er);
         wr(2'd1, 4'd2);
         settle();
         chk($sformatf("R5 code %0d column only", i), tone_out, ec);
         drain();
         chk($sformatf("R12 code %0d idle", i), tone_out, 0);
      end

      summary();
      $finish;
   end

endmodule